// File: doc/BRIEF.md
# Watchdog Timer with Interrupt-First Expiry and Reset-Cause Flags

This block counts clocks from its last restart. When the count runs out, it raises an interrupt request. If software does not restart it within a fixed grace window, the block issues a one-cycle system reset request. The reset request is only issued when software has armed the reset function. Software talks to it through a single 8-bit control register. In that register it arms the reset, restarts the count and reads the cause of the last reset.

Three synchronous reset sources feed the block: power-on/power-fail, external and watchdog. Each affects the cause flags in its own way. A power-on reset disarms the reset function, clears the watchdog-reset flag and sets the power-on flag. The external and watchdog reset sources only restart the timing, and they leave every control bit as it was. The watchdog-reset flag is set by the block itself when it issues a reset request.

The timeout is 2^TIMEOUT_BITS clocks. The grace window is GRACE_CLKS clocks and defaults to 512.

Top module: `wdog_guard`

## Requirements
- R1: After a power-on reset, the register reads 0x08, and both irq_o and rst_req_o are 0.
- R2: Register layout: bit 0 is the restart strobe, bit 1 is the reset-arm bit, bit 2 is the watchdog-reset flag and bit 3 is the power-on flag. Bit 0 and bits 7:4 always read 0.
- R3: A write with bit 0 set restarts the count. Expiry (the pending interrupt rising) happens exactly 2^TIMEOUT_BITS clock edges after the write edge.
- R4: At expiry an interrupt becomes pending, and irq_o is that pending state ANDed with irq_en_i. With irq_en_i low, irq_o stays 0 and the reset sequence still proceeds.
- R5: With the reset-arm bit at 1, rst_req_o goes high for exactly one cycle, GRACE_CLKS edges after the pending interrupt rose. At the same edge the pending interrupt clears and the watchdog-reset flag becomes 1.
- R6: With the reset-arm bit at 0, no reset request is issued and the watchdog-reset flag keeps its value. The pending interrupt still clears at the end of the grace window.
- R7: A restart write at any cycle of the grace window clears the pending interrupt and cancels the reset request.
- R8: Writing 0 to bit 2 or bit 3 clears that flag. Writing 1 to either leaves it unchanged.
- R9: A power-on reset clears the reset-arm bit and the watchdog-reset flag, and sets the power-on flag, whatever their previous values.
- R10: An external or watchdog reset input clears the pending interrupt and restarts the count. It leaves the reset-arm bit and both flags unchanged, and register writes made while it is asserted are ignored.
- R11: After the cycle of a reset request or the end of a grace window, the count restarts from zero. The next expiry comes 2^TIMEOUT_BITS edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_i | input | 1 | Power-on / power-fail reset, synchronous, active high |
| ext_rst_i | input | 1 | External reset, synchronous, active high |
| wdt_rst_i | input | 1 | Watchdog-caused system reset, synchronous, active high |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with TIMEOUT_BITS = 4 and GRACE_CLKS = 24. This shortens both windows enough that every edge of them can be checked against arithmetic expectations. At that size, a restart can be placed at every single offset of the grace window, including the last cycle before the reset would fire. The full expiry, grace, pulse and restart chain can also be walked cycle by cycle for each setting of the interrupt enable and the reset-arm bit.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  localparam int unsigned CTL_W     = 8;
  localparam int unsigned BIT_KICK  = 0;
  localparam int unsigned BIT_RSTEN = 1;
  localparam int unsigned BIT_WDRF  = 2;
  localparam int unsigned BIT_PORF  = 3;

  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_GRACE = 1'b1
  } wd_phase_e;

  typedef struct packed {
    logic rst_en;
    logic wdr_flag;
    logic por_flag;
  } wd_ctl_t;

  // counter width able to hold 0 .. n-1
  function automatic int unsigned ctr_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // control state -> read image; strobe and spare bits read as zero
  function automatic logic [CTL_W-1:0] pack_ctl(wd_ctl_t c);
    logic [CTL_W-1:0] v;
    v            = '0;
    v[BIT_RSTEN] = c.rst_en;
    v[BIT_WDRF]  = c.wdr_flag;
    v[BIT_PORF]  = c.por_flag;
    return v;
  endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
`timescale 1ns/1ps
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             por_i,
  input  logic             blk_rst_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             fire_set_i,
  output logic             kick_o,
  output wd_ctl_t          ctl_o,
  output logic [CTL_W-1:0] rd_data_o
);

  wd_ctl_t ctl_q;
  logic    wr_ok;

  assign wr_ok     = wr_en_i && !por_i && !blk_rst_i;
  assign kick_o    = wr_ok && wr_data_i[BIT_KICK];
  assign ctl_o     = ctl_q;
  assign rd_data_o = pack_ctl(ctl_q);

  always_ff @(posedge clk) begin
    if (por_i) begin
      ctl_q <= '{rst_en: 1'b0, wdr_flag: 1'b0, por_flag: 1'b1};
    end else begin
      if (wr_ok) begin
        ctl_q.rst_en <= wr_data_i[BIT_RSTEN];
        if (!wr_data_i[BIT_WDRF]) ctl_q.wdr_flag <= 1'b0;
        if (!wr_data_i[BIT_PORF]) ctl_q.por_flag <= 1'b0;
      end
      if (fire_set_i) ctl_q.wdr_flag <= 1'b1;
    end
  end

  AST_WDRF_SET: assert property (@(posedge clk) disable iff (por_i)
    fire_set_i |=> ctl_q.wdr_flag); // R5

  AST_WDRF_HOLD: assert property (@(posedge clk) disable iff (por_i)
    (!fire_set_i && !wr_ok) |=> $stable(ctl_q.wdr_flag)); // R10

  AST_RSTEN_HOLD: assert property (@(posedge clk) disable iff (por_i)
    !wr_ok |=> $stable(ctl_q.rst_en)); // R10

  AST_PORF_NO_SET: assert property (@(posedge clk) disable iff (por_i)
    !ctl_q.por_flag |=> !ctl_q.por_flag); // R8

endmodule

// File: rtl/wdog_timebase.sv
`timescale 1ns/1ps
module wdog_timebase #(
  parameter int unsigned TIMEOUT_BITS = 16
) (
  input  logic clk,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);

  localparam logic [TIMEOUT_BITS-1:0] TICK_MAX = '1;

  logic [TIMEOUT_BITS-1:0] tick_q;

  assign expire_o = run_i && !clr_i && (tick_q == TICK_MAX);

  always_ff @(posedge clk) begin
    if (clr_i)      tick_q <= '0;
    else if (run_i) tick_q <= tick_q + 1'b1;
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (clr_i)
    run_i |=> (tick_q == TIMEOUT_BITS'($past(tick_q) + 1'b1))); // R3

  AST_TICK_ZERO: assert property (@(posedge clk)
    clr_i |=> (tick_q == '0)); // R11

endmodule

// File: rtl/wdog_grace.sv
`timescale 1ns/1ps
module wdog_grace
  import wdog_pkg::*;
#(
  parameter int unsigned GRACE_CLKS = 512
) (
  input  logic clk,
  input  logic abort_i,
  input  logic expire_i,
  output logic in_grace_o,
  output logic fire_o
);

  localparam int unsigned GW = ctr_bits(GRACE_CLKS);
  localparam logic [GW-1:0] G_LAST = GW'(GRACE_CLKS - 1);

  wd_phase_e     phase_q;
  logic [GW-1:0] gcnt_q;

  assign in_grace_o = (phase_q == PH_GRACE);
  assign fire_o     = in_grace_o && (gcnt_q == G_LAST) && !abort_i;

  always_ff @(posedge clk) begin
    if (abort_i) begin
      phase_q <= PH_RUN;
      gcnt_q  <= '0;
    end else if (phase_q == PH_RUN) begin
      if (expire_i) begin
        phase_q <= PH_GRACE;
        gcnt_q  <= '0;
      end
    end else if (gcnt_q == G_LAST) begin
      phase_q <= PH_RUN;
      gcnt_q  <= '0;
    end else begin
      gcnt_q <= gcnt_q + 1'b1;
    end
  end

  AST_GRACE_ENTRY: assert property (@(posedge clk) disable iff (abort_i)
    (!in_grace_o && expire_i) |=> (in_grace_o && gcnt_q == '0)); // R4

  AST_GRACE_EXIT: assert property (@(posedge clk) disable iff (abort_i)
    fire_o |=> !in_grace_o); // R11

  AST_ABORT_CLEARS: assert property (@(posedge clk)
    abort_i |=> !in_grace_o); // R7

endmodule

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_BITS = 16,
  parameter int unsigned GRACE_CLKS   = 512
) (
  input  logic       clk,
  input  logic       por_rst_i,
  input  logic       ext_rst_i,
  input  logic       wdt_rst_i,
  input  logic       irq_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       rst_req_o
);

  // named internal events
  logic    blk_rst;
  logic    any_rst;
  logic    kick;
  logic    abort;
  logic    expire;
  logic    in_grace;
  logic    fire;
  logic    fire_set;
  logic    rst_req_q;
  wd_ctl_t ctl;

  assign blk_rst  = ext_rst_i || wdt_rst_i;
  assign any_rst  = por_rst_i || blk_rst;
  assign abort    = any_rst || kick;
  assign fire_set = fire && ctl.rst_en;

  wdog_ctrl_reg u_ctrl (
    .clk        (clk),
    .por_i      (por_rst_i),
    .blk_rst_i  (blk_rst),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .fire_set_i (fire_set),
    .kick_o     (kick),
    .ctl_o      (ctl),
    .rd_data_o  (rd_data_o)
  );

  wdog_timebase #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_timebase (
    .clk      (clk),
    .clr_i    (abort || fire),
    .run_i    (!in_grace),
    .expire_o (expire)
  );

  wdog_grace #(.GRACE_CLKS(GRACE_CLKS)) u_grace (
    .clk        (clk),
    .abort_i    (abort),
    .expire_i   (expire),
    .in_grace_o (in_grace),
    .fire_o     (fire)
  );

  always_ff @(posedge clk) begin
    if (any_rst) rst_req_q <= 1'b0;
    else         rst_req_q <= fire_set;
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = in_grace && irq_en_i;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (por_rst_i)
    rst_req_q |=> !rst_req_q); // R5

  AST_NO_REQ_UNARMED: assert property (@(posedge clk) disable iff (por_rst_i)
    (fire && !ctl.rst_en) |=> !rst_req_q); // R6

  AST_KICK_CANCELS: assert property (@(posedge clk) disable iff (por_rst_i)
    kick |=> (!in_grace && !rst_req_q)); // R7

  AST_REQ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (por_rst_i)
    rst_req_q |-> !in_grace); // R5

endmodule

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;

  localparam int unsigned TO_BITS = 4;
  localparam int unsigned GR      = 24;
  localparam int unsigned TO      = 1 << TO_BITS;

  logic       clk = 1'b0;
  logic       por_rst = 1'b1;
  logic       ext_rst = 1'b0;
  logic       wdt_rst = 1'b0;
  logic       irq_en  = 1'b1;
  logic       wr_en   = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  logic       rst_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_guard #(.TIMEOUT_BITS(TO_BITS), .GRACE_CLKS(GR)) u_wdog_guard (
    .clk       (clk),
    .por_rst_i (por_rst),
    .ext_rst_i (ext_rst),
    .wdt_rst_i (wdt_rst),
    .irq_en_i  (irq_en),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (irq),
    .rst_req_o (rst_req)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    step(1);
    wr_en   = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    por_rst = 1'b0;
    chk("R1 reg", rd_data, 8'h08);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rst_req", {7'd0, rst_req}, 8'h00);

    // layout: spare bits and strobe read 0; bit3 written 0 clears power flag
    wr(8'hF3);
    chk("R2 layout", rd_data, 8'h02);

    // full expiry -> grace -> pulse -> restart chain
    wr(8'h03);
    step(TO - 1);
    chk("R3 before expiry", {7'd0, irq}, 8'h00);
    step(1);
    chk("R3 expiry", {7'd0, irq}, 8'h01);
    for (int i = 1; i < int'(GR); i++) begin
      step(1);
      chk("R5 no early req", {7'd0, rst_req}, 8'h00);
    end
    step(1);
    chk("R5 req", {7'd0, rst_req}, 8'h01);
    chk("R5 irq cleared", {7'd0, irq}, 8'h00);
    chk("R5 flag set", rd_data, 8'h06);
    step(1);
    chk("R5 one cycle", {7'd0, rst_req}, 8'h00);
    step(TO - 2);
    chk("R11 before re-expiry", {7'd0, irq}, 8'h00);
    step(1);
    chk("R11 re-expiry", {7'd0, irq}, 8'h01);

    // flag write semantics
    wr(8'h07);
    chk("R8 wdr keep on 1", rd_data, 8'h06);
    wr(8'h03);
    chk("R8 wdr clear on 0", rd_data, 8'h02);
    wr(8'h07);
    chk("R8 wdr no set", rd_data, 8'h02);
    wr(8'h0B);
    chk("R8 por no set", rd_data, 8'h02);

    // restart at every offset of the grace window
    for (int d = 0; d < int'(GR); d++) begin
      wr(8'h03);
      step(TO);
      chk("R7 in grace", {7'd0, irq}, 8'h01);
      for (int k = 0; k < d; k++) begin
        step(1);
        chk("R7 no req before kick", {7'd0, rst_req}, 8'h00);
      end
      wr(8'h03);
      chk("R7 irq cleared", {7'd0, irq}, 8'h00);
      for (int k = 1; k < int'(TO); k++) begin
        step(1);
        chk("R7 cancelled", {6'd0, rst_req, irq}, 8'h00);
      end
      step(1);
      chk("R7 next expiry", {6'd0, rst_req, irq}, 8'h01);
    end
    chk("R7 flag untouched", rd_data, 8'h02);

    // interrupt masked, reset still issued
    irq_en = 1'b0;
    wr(8'h03);
    for (int i = 1; i <= int'(TO + GR); i++) begin
      step(1);
      chk("R4 masked irq", {7'd0, irq}, 8'h00);
      chk("R4 req with mask", {7'd0, rst_req}, (i == int'(TO + GR)) ? 8'h01 : 8'h00);
    end
    irq_en = 1'b1;

    // unarmed: no request, flag (1) kept, grace ends, count restarts
    wr(8'h05);
    chk("R6 unarmed reg", rd_data, 8'h04);
    step(TO);
    chk("R6 expiry", {7'd0, irq}, 8'h01);
    for (int i = 1; i <= int'(GR); i++) begin
      step(1);
      chk("R6 no req", {7'd0, rst_req}, 8'h00);
      chk("R6 irq", {7'd0, irq}, (i == int'(GR)) ? 8'h00 : 8'h01);
    end
    chk("R6 flag kept", rd_data, 8'h04);
    step(TO - 1);
    chk("R11 unarmed restart", {7'd0, irq}, 8'h00);
    step(1);
    chk("R11 unarmed re-expiry", {7'd0, irq}, 8'h01);

    // external reset with a write attempt during it
    wr(8'h07);
    chk("R10 armed", rd_data, 8'h06);
    step(TO + 3);
    chk("R10 in grace", {7'd0, irq}, 8'h01);
    ext_rst = 1'b1;
    wr_en   = 1'b1;
    wr_data = 8'h00;
    step(1);
    ext_rst = 1'b0;
    wr_en   = 1'b0;
    chk("R10 ext irq cleared", {7'd0, irq}, 8'h00);
    chk("R10 ext reg kept", rd_data, 8'h06);
    step(TO - 1);
    chk("R10 ext restart", {7'd0, irq}, 8'h00);
    step(1);
    chk("R10 ext re-expiry", {7'd0, irq}, 8'h01);
    wdt_rst = 1'b1;
    step(1);
    wdt_rst = 1'b0;
    chk("R10 wdt irq cleared", {7'd0, irq}, 8'h00);
    chk("R10 wdt reg kept", rd_data, 8'h06);

    // power-on again from armed, flagged state
    step(TO + 2);
    por_rst = 1'b1;
    step(2);
    por_rst = 1'b0;
    chk("R9 por reg", rd_data, 8'h08);
    chk("R9 por irq", {7'd0, irq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule